// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking two levels of translation tables held in memory. A client presents a virtual address on a request handshake. The walker reads one word from the directory, which a reloadable base register locates. That entry gives the frame of a page table. The walker then reads one word from that table, and that entry gives the physical page frame. The page offset is appended to this frame and the result is returned on a response handshake.

Each entry carries a present flag. If the flag is clear at either level, the walk stops at once. The response then reports a page fault, the level that failed, and the virtual address that caused it. Only one walk runs at a time. Reloading the base register switches to another address space for later walks and leaves the walk already in flight unchanged.

Top module: `ptw_walker`

## Requirements
- R1: The directory index is bits 31:22 of the virtual address. The first read of a walk goes to the directory frame plus four times that index. The directory frame is the base register with its low 12 bits treated as zero.
- R2: When the directory entry has bit 0 (present) set, the second read goes to that entry's bits 31:12 as a 4 KB frame, plus four times the table index in virtual address bits 21:12.
- R3: When the table entry is present, the response has fault = 0 and the physical address {table entry bits 31:12, virtual address bits 11:0}.
- R4: When the directory entry has bit 0 clear, exactly one memory read is made. The response has fault = 1, fault level = 0 and the request's virtual address.
- R5: When the table entry has bit 0 clear, exactly two memory reads are made. The response has fault = 1, fault level = 1 and the request's virtual address.
- R6: req_ready is high only when no walk is in progress and no response is pending. A request offered during a walk is not accepted.
- R7: A base register write takes effect for requests accepted in later cycles. A write during a walk does not change that walk's reads or its result.
- R8: Once mem_rd_valid is raised, it stays high with a stable mem_rd_addr until mem_rd_ready is seen. Each level makes only one read.
- R9: Once rsp_valid is raised, it stays high with stable contents until rsp_ready is seen. The walker then returns to idle.
- R10: Entry bits 11:1 have no effect on the walk or on the physical address. Index values 0 and 1023 at both levels are translated like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr | input | 1 | Load the directory base register |
| base_wdata | input | 32 | New directory base; bits 11:0 ignored |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Physical word address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read from memory |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Client takes the result |
| rsp_fault | output | 1 | 1 = page fault, 0 = translation |
| rsp_fault_lvl | output | 1 | Faulting level: 0 directory, 1 table |
| rsp_paddr | output | 32 | Physical address when not faulted |
| rsp_vaddr | output | 32 | Virtual address of this walk |

## Verification
The assertions are checked on every cycle. They cover the handshake rules: the memory read and the response hold steady while stalled, and req_ready stays low while a read or a result is outstanding. They also check that a successful result carries the virtual page offset, and that the directory read address carries the latched directory index. Only the bench scenarios can show that the right entries are fetched, that the two fault levels stop after the correct number of reads, and that a base reload is deferred to the next walk. The same holds for flag bits in entries and for the extreme index values. Each of these needs a memory image with known contents.

// File: rtl/ptw_pkg.sv
// Shared types for the page table walker.
// Assumes: nothing beyond IEEE 1800-2017.
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_READ_PTE,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    localparam logic LVL_DIR = 1'b0;
    localparam logic LVL_TBL = 1'b1;

endpackage

// File: rtl/ptw_va_split.sv
// Splits a virtual address into directory index, table index and page offset.
// Assumes: DIR_W + TBL_W + OFF_W == VA_W, directory index on top.
module ptw_va_split #(
    parameter int VA_W  = 32,
    parameter int DIR_W = 10,
    parameter int TBL_W = 10,
    parameter int OFF_W = 12
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [DIR_W-1:0] dir_idx,
    output logic [TBL_W-1:0] tbl_idx,
    output logic [OFF_W-1:0] offset
);

    // Field extraction, purely combinational.
    assign dir_idx = vaddr[VA_W-1 -: DIR_W];
    assign tbl_idx = vaddr[OFF_W +: TBL_W];
    assign offset  = vaddr[OFF_W-1:0];

endmodule

// File: rtl/ptw_entry_addr.sv
// Forms the byte address of a table entry from a frame number and an index.
// Assumes: tables are frame aligned and entries are 2**ENT_LG bytes wide.
module ptw_entry_addr #(
    parameter int PA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    parameter int ENT_LG = 2
) (
    input  logic [PA_W-OFF_W-1:0] frame,
    input  logic [IDX_W-1:0]      idx,
    output logic [PA_W-1:0]       addr
);

    localparam logic [OFF_W-1:0] ZERO_OFF = '0;

    // Frame base plus scaled index.
    assign addr = {frame, ZERO_OFF} + (PA_W'(idx) << ENT_LG);

endmodule

// File: rtl/ptw_walker.sv
// Two-level page table walker: one request at a time, two dependent
// entry reads, present-bit check at each level, fault or translation result.
// Assumes: entries are PA_W bits, frame in bits PA_W-1:OFF_W, present in bit 0;
// memory returns exactly one mem_rsp_valid pulse per accepted read.
module ptw_walker #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int DIR_W = 10,
    parameter int TBL_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_wr,
    input  logic [PA_W-1:0] base_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            mem_rd_valid,
    input  logic            mem_rd_ready,
    output logic [PA_W-1:0] mem_rd_addr,
    input  logic            mem_rsp_valid,
    input  logic [PA_W-1:0] mem_rsp_data,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic            rsp_fault,
    output logic            rsp_fault_lvl,
    output logic [PA_W-1:0] rsp_paddr,
    output logic [VA_W-1:0] rsp_vaddr
);
    import ptw_pkg::*;

    localparam int OFF_W   = VA_W - DIR_W - TBL_W;
    localparam int FRAME_W = PA_W - OFF_W;
    localparam int IDX_W   = (DIR_W > TBL_W) ? DIR_W : TBL_W;
    localparam int PRES_B  = 0;

    walk_state_t        state_q;
    logic               issued_q;
    logic [PA_W-1:0]    base_q;
    logic [VA_W-1:0]    vaddr_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic [PA_W-1:0]    paddr_q;
    logic               lvl_q;

    logic [DIR_W-1:0]   dir_idx;
    logic [TBL_W-1:0]   tbl_idx;
    logic [OFF_W-1:0]   pg_off;
    logic [FRAME_W-1:0] sel_frame;
    logic [IDX_W-1:0]   sel_idx;
    logic               in_read;
    logic               rd_fire;
    logic               rsp_in;
    logic               ent_present;

    ptw_va_split #(
        .VA_W(VA_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W)
    ) i_split (
        .vaddr(vaddr_q), .dir_idx(dir_idx), .tbl_idx(tbl_idx), .offset(pg_off)
    );

    // Select the frame and index for the level being read.
    always_comb begin
        if (state_q == ST_READ_PTE) begin
            sel_frame = tbl_frame_q;
            sel_idx   = IDX_W'(tbl_idx);
        end else begin
            sel_frame = dir_frame_q;
            sel_idx   = IDX_W'(dir_idx);
        end
    end

    ptw_entry_addr #(
        .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LG(2)
    ) i_eaddr (
        .frame(sel_frame), .idx(sel_idx), .addr(mem_rd_addr)
    );

    assign in_read      = (state_q == ST_READ_DIR) || (state_q == ST_READ_PTE);
    assign mem_rd_valid = in_read && !issued_q;
    assign rd_fire      = mem_rd_valid && mem_rd_ready;
    assign rsp_in       = in_read && issued_q && mem_rsp_valid;
    assign ent_present  = mem_rsp_data[PRES_B];

    assign req_ready     = (state_q == ST_IDLE);
    assign rsp_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
    assign rsp_fault     = (state_q == ST_FAULT);
    assign rsp_fault_lvl = lvl_q;
    assign rsp_paddr     = paddr_q;
    assign rsp_vaddr     = vaddr_q;

    // Directory base register, reloadable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else if (base_wr) base_q <= base_wdata;
    end

    // Walk sequencer: accept, read directory, read table, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            issued_q    <= 1'b0;
            vaddr_q     <= '0;
            dir_frame_q <= '0;
            tbl_frame_q <= '0;
            paddr_q     <= '0;
            lvl_q       <= LVL_DIR;
        end else begin
            if (rd_fire) issued_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q     <= req_vaddr;
                        dir_frame_q <= base_q[PA_W-1:OFF_W];
                        paddr_q     <= '0;
                        lvl_q       <= LVL_DIR;
                        issued_q    <= 1'b0;
                        state_q     <= ST_READ_DIR;
                    end
                end
                ST_READ_DIR: begin
                    if (rsp_in) begin
                        issued_q <= 1'b0;
                        if (ent_present) begin
                            tbl_frame_q <= mem_rsp_data[PA_W-1:OFF_W];
                            state_q     <= ST_READ_PTE;
                        end else begin
                            lvl_q   <= LVL_DIR;
                            state_q <= ST_FAULT;
                        end
                    end
                end
                ST_READ_PTE: begin
                    if (rsp_in) begin
                        issued_q <= 1'b0;
                        if (ent_present) begin
                            paddr_q <= {mem_rsp_data[PA_W-1:OFF_W], pg_off};
                            state_q <= ST_DONE;
                        end else begin
                            lvl_q   <= LVL_TBL;
                            state_q <= ST_FAULT;
                        end
                    end
                end
                ST_DONE, ST_FAULT: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R6: no acceptance while a read or a result is outstanding.
    p_busy_blocks_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || rsp_valid) |-> !req_ready);

    // R8: a stalled memory read keeps its request and address.
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R9: a stalled response keeps its contents.
    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault)
            && $stable(rsp_paddr) && $stable(rsp_vaddr) && $stable(rsp_fault_lvl)));

    // R3: a translation keeps the page offset of the request.
    p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]));

    // R1: the directory read is indexed by the top bits of the walked address.
    p_dir_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && state_q == ST_READ_DIR)
            |-> (mem_rd_addr[OFF_W-1:2] == rsp_vaddr[VA_W-1 -: DIR_W]));

endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic        rsp_fault_lvl;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_vaddr;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic        mem_gate = 1'b1;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] rd_log [0:7];
    int          rd_cnt = 0;
    int          lat_cnt = 0;
    logic [31:0] pend_addr = '0;

    always #2 clk = ~clk;

    assign mem_rd_ready = mem_gate;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
        .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr)
    );

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory model: two-cycle read latency, one response pulse per read.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd_mem(pend_addr);
                end
            end
            if (mem_rd_valid && mem_rd_ready) begin
                pend_addr = mem_rd_addr;
                if (rd_cnt < 8) rd_log[rd_cnt] = mem_rd_addr;
                rd_cnt++;
                lat_cnt = 2;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic offer(input logic [31:0] va);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_cnt = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp();
        while (!rsp_valid) @(negedge clk);
    endtask

    task automatic take_rsp();
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic load_base(input logic [31:0] b);
        @(negedge clk);
        base_wr = 1'b1;
        base_wdata = b;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R6 reset req_ready", {31'b0, req_ready}, 32'h1);
        check(rsp_valid == 1'b0, "R9 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check(mem_rd_valid == 1'b0, "R8 reset mem_rd_valid", {31'b0, mem_rd_valid}, 32'h0);
    endtask

    // R1 R2 R3 R10: translation with flag bits set in both entries.
    task automatic t_translate();
        offer(32'h0040_3ABC);
        wait_rsp();
        check(rd_cnt == 2, "R2 two reads", rd_cnt, 2);
        check(rd_log[0] == 32'h0001_0004, "R1 directory address", rd_log[0], 32'h0001_0004);
        check(rd_log[1] == 32'h0002_000C, "R2 table address", rd_log[1], 32'h0002_000C);
        check(rsp_fault == 1'b0, "R3 no fault", {31'b0, rsp_fault}, 32'h0);
        check(rsp_paddr == 32'h0ABC_DABC, "R10 R3 physical address", rsp_paddr, 32'h0ABC_DABC);
        take_rsp();
    endtask

    // R10: top index values at both levels.
    task automatic t_edges();
        offer(32'hFFFF_FFFF);
        wait_rsp();
        check(rd_log[0] == 32'h0001_0FFC, "R10 directory index 1023", rd_log[0], 32'h0001_0FFC);
        check(rd_log[1] == 32'h0003_0FFC, "R10 table index 1023", rd_log[1], 32'h0003_0FFC);
        check(rsp_paddr == 32'h1234_5FFF, "R10 max address result", rsp_paddr, 32'h1234_5FFF);
        take_rsp();
    endtask

    // R4: directory entry not present.
    task automatic t_dir_fault();
        offer(32'h0000_0123);
        wait_rsp();
        repeat (4) @(negedge clk);
        check(rd_cnt == 1, "R4 one read", rd_cnt, 1);
        check(rd_log[0] == 32'h0001_0000, "R4 index 0 address", rd_log[0], 32'h0001_0000);
        check(rsp_fault && rsp_fault_lvl == 1'b0, "R4 fault level 0",
              {30'b0, rsp_fault, rsp_fault_lvl}, 32'h2);
        check(rsp_vaddr == 32'h0000_0123, "R4 fault vaddr", rsp_vaddr, 32'h0000_0123);
        take_rsp();
    endtask

    // R5: table entry not present.
    task automatic t_tbl_fault();
        offer(32'h0040_4567);
        wait_rsp();
        check(rd_cnt == 2, "R5 two reads", rd_cnt, 2);
        check(rsp_fault && rsp_fault_lvl == 1'b1, "R5 fault level 1",
              {30'b0, rsp_fault, rsp_fault_lvl}, 32'h3);
        check(rsp_vaddr == 32'h0040_4567, "R5 fault vaddr", rsp_vaddr, 32'h0040_4567);
        take_rsp();
    endtask

    // R6: a second request held during a walk is not taken.
    task automatic t_busy();
        int bad = 0;
        offer(32'h0040_3ABC);
        req_valid = 1'b1;
        req_vaddr = 32'hFFFF_FFFF;
        while (!rsp_valid) begin
            if (req_ready) bad++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(bad == 0, "R6 req_ready low while busy", bad, 0);
        check(rsp_vaddr == 32'h0040_3ABC, "R6 first request kept", rsp_vaddr, 32'h0040_3ABC);
        take_rsp();
    endtask

    // R8: memory stall holds the read request.
    task automatic t_mem_stall();
        int bad = 0;
        logic [31:0] a0;
        @(posedge clk); #1 mem_gate = 1'b0;
        offer(32'h0040_3ABC);
        a0 = mem_rd_addr;
        repeat (5) begin
            if (!mem_rd_valid || mem_rd_addr != a0) bad++;
            @(negedge clk);
        end
        @(posedge clk); #1 mem_gate = 1'b1;
        wait_rsp();
        check(bad == 0, "R8 read held while stalled", bad, 0);
        check(rd_cnt == 2, "R8 one read per level", rd_cnt, 2);
        check(rsp_paddr == 32'h0ABC_DABC, "R8 result after stall", rsp_paddr, 32'h0ABC_DABC);
        take_rsp();
    endtask

    // R9: response stays until taken, then walker idles.
    task automatic t_rsp_hold();
        int bad = 0;
        offer(32'hFFFF_FFFF);
        wait_rsp();
        repeat (4) begin
            @(negedge clk);
            if (!rsp_valid || rsp_paddr != 32'h1234_5FFF) bad++;
        end
        check(bad == 0, "R9 response held", bad, 0);
        take_rsp();
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 idle after take",
              {30'b0, rsp_valid, req_ready}, 32'h1);
    endtask

    // R7: base reload mid-walk is deferred, then used.
    task automatic t_reload();
        offer(32'h0040_3ABC);
        base_wr = 1'b1;
        base_wdata = 32'h0005_0123;
        @(negedge clk);
        base_wr = 1'b0;
        wait_rsp();
        check(rd_log[0] == 32'h0001_0004, "R7 walk keeps old base", rd_log[0], 32'h0001_0004);
        check(rsp_paddr == 32'h0ABC_DABC, "R7 old space result", rsp_paddr, 32'h0ABC_DABC);
        take_rsp();
        offer(32'h0040_3ABC);
        wait_rsp();
        check(rd_log[0] == 32'h0005_0004, "R7 new base used", rd_log[0], 32'h0005_0004);
        check(rsp_paddr == 32'h0777_7ABC, "R7 new space result", rsp_paddr, 32'h0777_7ABC);
        take_rsp();
    endtask

    initial begin
        #200000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        mem[32'h0001_0004] = 32'h0002_0FFF;
        mem[32'h0002_000C] = 32'h0ABC_DFFF;
        mem[32'h0001_0FFC] = 32'h0003_0001;
        mem[32'h0003_0FFC] = 32'h1234_5001;
        mem[32'h0002_0010] = 32'hDEAD_EFFE;
        mem[32'h0005_0004] = 32'h0006_0001;
        mem[32'h0006_000C] = 32'h0777_7001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        load_base(32'h0001_0000);
        t_translate();
        t_edges();
        t_dir_fault();
        t_tbl_fault();
        t_busy();
        t_mem_stall();
        t_rsp_hold();
        t_reload();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule